// File: doc/BRIEF.md
# Single-Line Signalling Code Detector

This block looks for a short signalling code that a broadcaster places on one fixed line of each video field. It counts horizontal sync strobes from the last vertical sync strobe to find that line, then samples the sliced luminance bit once on each of five sampling ticks. The first tick counts only after a programmable start delay has run out. The five samples are compared in order with a fixed five-bit pattern. If all five agree by the time the line ends, the identification output goes high, and it stays at that value until the next field makes a new decision.

A second output is high for the whole of the target line. Neighbouring logic uses it to gate a comb-filter bypass on that line. The analog slicer and any analog timing network sit outside the block. They supply the sliced bit, the tick strobe and a delay value counted in clock cycles.

Top module: `nrz_line_code_detector`

## Requirements
- R1: After reset, `code_found` and `line_mark` are low. The line counter stays idle and `line_mark` stays low for any number of `hsync` strobes until the first `vsync` strobe arrives.
- R2: A `vsync` strobe sets the line number to 1, and `vsync` has priority over `hsync`. Each `hsync` strobe after that adds one. `line_mark` is high from the clock after the hsync that begins line TARGET_LINE (22 by default) until the clock after the next hsync or vsync, and low at all other times.
- R3: The delay value present with the hsync that begins the target line sets the start delay D, in clock cycles. Counting the clock edge of that hsync as edge 0, a tick at edge k with k ≤ D is ignored.
- R4: From edge D+1 onward, each tick with no hsync or vsync in the same cycle takes one sample of `luma_bit`. The samples are compared in order with the pattern 1,0,1,1,0, first sample first (PATTERN bit 4 is compared first). If all five match, `code_found` is 1 after the strobe that ends the line.
- R5: `code_found` changes only at the clock of the hsync or vsync strobe that ends the target line. It holds its value through the rest of that field and through the following field.
- R6: If any of the five samples differs from its pattern bit, `code_found` is 0 for that field.
- R7: If fewer than five samples are taken before the target line ends, `code_found` is 0.
- R8: Ticks after the fifth sample on the target line are ignored, whatever the sliced bit is.
- R9: Ticks and sliced bits on any other line have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | One-cycle horizontal sync strobe |
| vsync | input | 1 | One-cycle vertical sync strobe |
| luma_bit | input | 1 | Sliced luminance bit |
| sample_tick | input | 1 | One-cycle sampling clock tick |
| start_delay | input | DLY_W | Start delay in clock cycles, taken at the start of the target line |
| code_found | output | 1 | Identification result, updated once per field |
| line_mark | output | 1 | High for the whole of the target line |

## Verification
The bench builds the block with DLY_W set to 5, so the largest delay, 31 cycles, is an ordinary directed case: a tick placed inside that delay must be skipped. With 72-cycle lines, the full delay, eight ticks and gaps of up to two cycles all fit inside the target line. The bench can therefore cover short runs of ticks, exact runs and runs with extra ticks, as well as noise on line 21. TARGET_LINE and the pattern keep their default values, so the bench works through 24 lines in every field.

// File: rtl/nrz_line_code_detector.sv
`timescale 1ns/1ps
module nrz_line_code_detector #(
  parameter int LINE_W      = 10,
  parameter int TARGET_LINE = 22,
  parameter int DLY_W       = 8,
  parameter int NBITS       = 5,
  parameter logic [NBITS-1:0] PATTERN = 5'b10110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             luma_bit,
  input  logic             sample_tick,
  input  logic [DLY_W-1:0] start_delay,
  output logic             code_found,
  output logic             line_mark
);
  localparam int CNT_W = $clog2(NBITS + 1);
  localparam logic [LINE_W-1:0] TGT      = LINE_W'(TARGET_LINE);
  localparam logic [LINE_W-1:0] TGT_PREV = LINE_W'(TARGET_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [CNT_W-1:0]  FULL     = CNT_W'(NBITS);

  logic [LINE_W-1:0] line_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  samp_cnt;
  logic              match_q;
  logic [NBITS-1:0]  pat_sh;

  wire on_target  = (line_q == TGT);
  wire line_start = hsync && !vsync && (line_q == TGT_PREV);
  wire line_end   = on_target && (hsync || vsync);
  wire take       = on_target && !hsync && !vsync && sample_tick &&
                    (dly_q == '0) && (samp_cnt < FULL);

  assign pat_sh    = PATTERN << samp_cnt;
  assign line_mark = on_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_q <= '0;
    else if (vsync)
      line_q <= LINE_W'(1);
    else if (hsync && line_q != '0 && line_q != LINE_MAX)
      line_q <= line_q + LINE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q    <= '0;
      samp_cnt <= '0;
      match_q  <= 1'b0;
    end else if (line_start) begin
      dly_q    <= start_delay;
      samp_cnt <= '0;
      match_q  <= 1'b1;
    end else begin
      if (dly_q != '0)
        dly_q <= dly_q - DLY_W'(1);
      if (take) begin
        samp_cnt <= samp_cnt + CNT_W'(1);
        match_q  <= match_q && (luma_bit == pat_sh[NBITS-1]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code_found <= 1'b0;
    else if (line_end)
      code_found <= match_q && (samp_cnt == FULL);
  end
endmodule

module nrz_line_code_chk #(
  parameter int DLY_W = 8,
  parameter int CNT_W = 3,
  parameter int NBITS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             vsync,
  input logic             code_found,
  input logic             line_mark,
  input logic [DLY_W-1:0] dly_q,
  input logic [CNT_W-1:0] samp_cnt
);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_mark && (hsync || vsync)) |=> $stable(code_found));
  // R2
  vsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> !line_mark);
  // R2
  mark_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mark && hsync) |=> !line_mark);
  // R3
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q != '0 && !hsync && !vsync) |=> $stable(samp_cnt));
  // R9
  off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_mark && !hsync) |=> $stable(samp_cnt));
  // R8
  sample_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_cnt == CNT_W'(NBITS) && !hsync) |=> $stable(samp_cnt));
  // R7
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_found) |-> $past(samp_cnt) == CNT_W'(NBITS));
endmodule

bind nrz_line_code_detector nrz_line_code_chk #(
  .DLY_W(DLY_W), .CNT_W(CNT_W), .NBITS(NBITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
  .code_found(code_found), .line_mark(line_mark),
  .dly_q(dly_q), .samp_cnt(samp_cnt)
);

// File: tb/nrz_line_code_detector_tb.sv
`timescale 1ns/1ps
module nrz_line_code_detector_tb;
  localparam int DW = 5;
  localparam int LINE_LEN = 72;
  localparam logic [4:0] PAT = 5'b10110;
  localparam logic [7:0] GOOD = 8'b0000_1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, lb = 1'b0, tk = 1'b0;
  logic [DW-1:0] dly = '0;
  logic found, mark;

  int m_line = 0, m_since = 0, m_cnt = 0, m_d = 0;
  bit m_ok = 1'b0, m_found = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nrz_line_code_detector #(.DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hs), .vsync(vs), .luma_bit(lb),
    .sample_tick(tk), .start_delay(dly), .code_found(found), .line_mark(mark)
  );

  function automatic bit pat_bit(int i);
    return PAT[4 - i];
  endfunction

  function automatic bit expect_of(logic [7:0] seq, int nt);
    if (nt < 5) return 1'b0;
    for (int i = 0; i < 5; i++)
      if (seq[i] != pat_bit(i)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit h, bit v, bit l, bit t);
    bit on;
    @(negedge clk);
    chk(found, m_found, "R5", "code_found per cycle");
    chk(mark, m_line == 22, "R2", "line_mark per cycle");
    hs = h; vs = v; lb = l; tk = t;
    @(posedge clk);
    on = (m_line == 22);
    if (on && (h || v)) m_found = m_ok && (m_cnt == 5);
    if (on && !h && !v && t && m_since >= m_d && m_cnt < 5) begin
      m_ok = m_ok && (l == pat_bit(m_cnt));
      m_cnt++;
    end
    if (!v && h && m_line == 21) begin
      m_since = 0; m_cnt = 0; m_ok = 1'b1; m_d = int'(dly);
    end else m_since++;
    if (v) m_line = 1;
    else if (h && m_line != 0) m_line++;
  endtask

  task automatic run_field(int d, logic [7:0] seq, int nt, bit early, bit noise21);
    int c;
    dly = DW'(d);
    cyc(0, 1, 0, 0);
    repeat (5) cyc(0, 0, 0, 0);
    for (int ln = 1; ln <= 24; ln++) begin
      cyc(1, 0, 0, 0);
      c = 1;
      if (ln + 1 == 22) begin
        if (early && d > 0) begin
          cyc(0, 0, !pat_bit(0), 1);
          c++;
        end
        while (c <= d) begin cyc(0, 0, 0, 0); c++; end
        for (int i = 0; i < nt; i++) begin
          repeat ($urandom_range(0, 2)) begin cyc(0, 0, 0, 0); c++; end
          cyc(0, 0, seq[i], 1);
          c++;
        end
      end else if (ln + 1 == 21 && noise21) begin
        for (int i = 0; i < 20; i++) begin
          cyc(0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
          c++;
        end
      end
      while (c < LINE_LEN) begin cyc(0, 0, 0, 0); c++; end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    logic [7:0] seq;
    int nt, d;
    r = $urandom(32'd4242);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(found, 1'b0, "R1", "code_found in reset");
    chk(mark, 1'b0, "R1", "line_mark in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 25; i++) begin
      cyc(1, 0, 1, 1);
      repeat (3) cyc(0, 0, 1, 1);
    end
    @(negedge clk);
    chk(mark, 1'b0, "R1", "marker idle before first vsync");
    chk(found, 1'b0, "R1", "no result before first vsync");

    run_field(0, GOOD, 5, 0, 0);
    chk(found, 1'b1, "R4", "exact pattern, zero delay");
    run_field(3, GOOD ^ 8'b0000_0001, 5, 0, 0);
    chk(found, 1'b0, "R6", "first bit wrong");
    run_field(31, GOOD, 5, 1, 0);
    chk(found, 1'b1, "R3", "tick inside max delay ignored");
    run_field(7, GOOD ^ 8'b0001_0000, 5, 0, 0);
    chk(found, 1'b0, "R6", "last bit wrong");
    run_field(2, GOOD, 4, 0, 0);
    chk(found, 1'b0, "R7", "only four samples");
    run_field(5, GOOD | 8'b1110_0000, 8, 0, 0);
    chk(found, 1'b1, "R8", "ticks after fifth ignored");
    run_field(1, GOOD, 5, 0, 1);
    chk(found, 1'b1, "R9", "line 21 noise ignored");
    run_field(9, GOOD, 2, 0, 0);
    chk(found, 1'b0, "R5", "result replaced next field");

    for (int f = 0; f < 18; f++) begin
      d = $urandom_range(0, 31);
      nt = $urandom_range(3, 8);
      seq = ($urandom_range(0, 1) == 1) ? (GOOD ^ 8'(1 << $urandom_range(0, 7)))
                                         : 8'($urandom_range(0, 255));
      run_field(d, seq, nt, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      chk(found, expect_of(seq, nt), "R4", "random field decision");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule